// File: doc/BRIEF.md
# PoE Port Detection Sequencer

This block sequences one Power over Ethernet supply port. Once reset is released it works without outside help. It asks the detection front end to probe the port. When the result is a valid signature, it asks the classification front end to classify the device. After classification it turns on the output switch and holds it on. A failed detection is retried, and the retries continue until a valid device answers.

Three strap pins are read once, at the first clock edge after reset is released. The midspan strap adds a cadence back-off of 2.0 to 2.4 s after every failed detection. The length of each back-off is drawn from a free-running LFSR. The legacy strap is passed on to the detection front end to allow high-capacitance signatures. The oscillator strap picks which prescaler divisor makes the 1 ms tick. After that first edge, changes on the straps have no effect until the next reset.

The analog probing, the classification decoding and any fault handling after power-up are done outside this block. They report back over the done and valid inputs.

Top module: `poe_port_seq`

## Requirements
- R1: While `rst_n` is low, `det_start`, `cls_start` and `sw_en` are 0 and `hicap_en` is 1.
- R2: The first clock edge after reset release raises `det_start` for exactly one cycle, whatever the midspan strap.
- R3: The straps are captured at the first clock edge after reset release. `hicap_en` then equals the captured legacy strap, and later strap changes have no effect until the next reset.
- R4: When `det_done` and `det_valid` are both 1 during detection, `cls_start` pulses for one cycle after the next edge. After `cls_done`, `sw_en` goes to 1 and stays at 1.
- R5: `sw_en` is 0 from reset release until classification completes, which covers every detection and back-off.
- R6: With midspan captured as 1, `det_start` follows a failed detection (`det_done`=1, `det_valid`=0) after no less than 2000 and no more than 2400 tick periods.
- R7: With midspan captured as 0, `det_start` follows a failed detection within one tick period.
- R8: Detection is retried after every failure, with no limit on the number of attempts.
- R9: A captured oscillator strap of 0 gives a tick every `MS_DIV_NORM` clocks. A value of 1 gives a tick every `MS_DIV_ALT` clocks.
- R10: `det_done` has no effect outside detection, and `cls_done` has no effect outside classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_midspan | input | 1 | Midspan cadence strap |
| strap_legacy | input | 1 | High-capacitance acceptance strap |
| strap_osc | input | 1 | Tick divisor select strap |
| det_start | output | 1 | One-cycle request to the detection front end |
| det_done | input | 1 | Detection result strobe |
| det_valid | input | 1 | Detection found a valid signature (qualified by det_done) |
| hicap_en | output | 1 | Captured legacy strap to the detection front end |
| cls_start | output | 1 | One-cycle request to the classification front end |
| cls_done | input | 1 | Classification finished |
| sw_en | output | 1 | Output switch enable |

## Verification
A failed detection can arrive on the same edge as a millisecond tick. In that case the back-off load must win, and the tick in that cycle must not shorten the wait. The bench delays each failed detection by a different number of cycles, so that it lands at every phase of the prescaler. Each measured gap to the next `det_start` is checked against the bounds for the captured mode. A gap shorter than two cycles, or more than one tick short of the minimum, shows that the tick was counted during the load.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;
  typedef enum logic [2:0] {
    PS_IDLE     = 3'd0,
    PS_DETECT   = 3'd1,
    PS_BACKOFF  = 3'd2,
    PS_CLASSIFY = 3'd3,
    PS_POWERED  = 3'd4
  } port_state_e;
endpackage

// File: rtl/poe_ms_tick.sv
module poe_ms_tick #(
  parameter int DIV_A = 25000,
  parameter int DIV_B = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_sel,
  output logic tick
);
  localparam int MAXD = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW   = $clog2(MAXD) + 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  assign lim   = alt_sel ? CW'(DIV_B - 1) : CW'(DIV_A - 1);
  assign tick  = (cnt_q >= lim);
  assign cnt_d = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAXD - 1)); // R9
endmodule

// File: rtl/poe_cadence_lfsr.sv
module poe_cadence_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter int          SPAN = 400,
  localparam int         SW   = $clog2(SPAN + 1),
  localparam int         PW   = W + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] offset
);
  logic [W-1:0] q, q_d;

  assign q_d    = {1'b0, q[W-1:1]} ^ (q[0] ? W'(TAPS) : '0);
  // scale the state into [0, SPAN-1] by a multiply, no divider needed
  assign offset = SW'((PW'(q) * PW'(SPAN)) >> W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= W'(SEED);
    else        q <= q_d;
  end

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    q != '0); // R6
  AST_OFFSET_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    offset < SW'(SPAN)); // R6
endmodule

// File: rtl/poe_backoff_timer.sv
module poe_backoff_timer #(
  parameter int MAX_MS = 2400,
  localparam int MSW   = $clog2(MAX_MS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MSW-1:0] load_ms,
  input  logic           tick,
  output logic           expire
);
  logic           active_q, active_d;
  logic [MSW-1:0] left_q, left_d;

  assign expire = active_q && tick && (left_q == '0);

  always_comb begin
    active_d = active_q;
    left_d   = left_q;
    if (load) begin
      active_d = 1'b1;
      left_d   = load_ms;
    end else if (expire) begin
      active_d = 1'b0;
    end else if (active_q && tick) begin
      left_d   = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else begin
      active_q <= active_d;
      left_q   <= left_d;
    end
  end

  AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q && left_q == $past(load_ms))); // R6
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (left_q <= MSW'(MAX_MS))); // R6
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
  import poe_seq_pkg::*;
#(
  parameter int          MS_DIV_NORM = 25000,
  parameter int          MS_DIV_ALT  = 32000,
  parameter int          CAD_BASE_MS = 2000,
  parameter int          CAD_SPAN_MS = 400,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_midspan,
  input  logic strap_legacy,
  input  logic strap_osc,
  output logic det_start,
  input  logic det_done,
  input  logic det_valid,
  output logic hicap_en,
  output logic cls_start,
  input  logic cls_done,
  output logic sw_en
);
  localparam int MAX_MS = CAD_BASE_MS + CAD_SPAN_MS;
  localparam int MSW    = $clog2(MAX_MS + 1);
  localparam int SW     = $clog2(CAD_SPAN_MS + 1);

  port_state_e    state_q, state_d;
  logic           mid_q, leg_q, osc_q, strap_cap;
  logic           det_start_q, det_start_d;
  logic           cls_start_q, cls_start_d;
  logic           sw_en_q, sw_en_d;
  logic           tick, expire, t_load;
  logic [SW-1:0]  offset;
  logic [MSW-1:0] load_ms;

  poe_ms_tick #(.DIV_A(MS_DIV_NORM), .DIV_B(MS_DIV_ALT)) u_tick (
    .clk(clk), .rst_n(rst_n), .alt_sel(osc_q), .tick(tick));

  poe_cadence_lfsr #(.W(16), .SEED(LFSR_SEED), .TAPS(16'hB400),
                     .SPAN(CAD_SPAN_MS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .offset(offset));

  poe_backoff_timer #(.MAX_MS(MAX_MS)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_ms(load_ms),
    .tick(tick), .expire(expire));

  assign strap_cap = (state_q == PS_IDLE);
  assign load_ms   = mid_q ? (MSW'(CAD_BASE_MS) + MSW'(offset)) : '0;

  always_comb begin
    state_d     = state_q;
    det_start_d = 1'b0;
    cls_start_d = 1'b0;
    t_load      = 1'b0;
    unique case (state_q)
      PS_IDLE: begin
        state_d     = PS_DETECT;
        det_start_d = 1'b1;
      end
      PS_DETECT: begin
        if (det_done) begin
          if (det_valid) begin
            state_d     = PS_CLASSIFY;
            cls_start_d = 1'b1;
          end else begin
            state_d = PS_BACKOFF;
            t_load  = 1'b1;
          end
        end
      end
      PS_BACKOFF: begin
        if (expire) begin
          state_d     = PS_DETECT;
          det_start_d = 1'b1;
        end
      end
      PS_CLASSIFY: begin
        if (cls_done) state_d = PS_POWERED;
      end
      PS_POWERED: state_d = PS_POWERED;
      default:    state_d = PS_IDLE;
    endcase
    sw_en_d = (state_d == PS_POWERED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_IDLE;
      det_start_q <= 1'b0;
      cls_start_q <= 1'b0;
      sw_en_q     <= 1'b0;
    end else begin
      state_q     <= state_d;
      det_start_q <= det_start_d;
      cls_start_q <= cls_start_d;
      sw_en_q     <= sw_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= 1'b1;
      leg_q <= 1'b1;
      osc_q <= 1'b0;
    end else if (strap_cap) begin
      mid_q <= strap_midspan;
      leg_q <= strap_legacy;
      osc_q <= strap_osc;
    end
  end

  assign det_start = det_start_q;
  assign cls_start = cls_start_q;
  assign sw_en     = sw_en_q;
  assign hicap_en  = leg_q;

  AST_FIRST_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_IDLE) |=> det_start); // R2
  AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |=> !det_start); // R2
  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_IDLE) |=> ($stable(mid_q) && $stable(leg_q) && $stable(osc_q))); // R3
  AST_CLS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_start |=> !cls_start); // R4
  AST_SW_LATCHED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> sw_en); // R4
  AST_SW_OFF_PROBING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DETECT || state_q == PS_BACKOFF) |-> !sw_en); // R5
endmodule

// File: tb/poe_port_seq_test.sv
module poe_port_seq_test;
  localparam int DA   = 4;
  localparam int DB   = 7;
  localparam int BASE = 2000;
  localparam int SPAN = 400;

  // vector fields: [5]=midspan [4]=legacy [3]=osc [2:0]=failures before valid
  localparam logic [5:0] VEC [4] = '{6'b110_010, 6'b000_011, 6'b101_001, 6'b011_010};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_midspan = 1'b1, strap_legacy = 1'b1, strap_osc = 1'b0;
  logic det_done = 1'b0, det_valid = 1'b0, cls_done = 1'b0;
  logic det_start, hicap_en, cls_start, sw_en;
  int   errors = 0;
  int   checks = 0;

  always #5 clk = ~clk;

  poe_port_seq #(.MS_DIV_NORM(DA), .MS_DIV_ALT(DB), .CAD_BASE_MS(BASE),
                 .CAD_SPAN_MS(SPAN)) uut (
    .clk(clk), .rst_n(rst_n), .strap_midspan(strap_midspan),
    .strap_legacy(strap_legacy), .strap_osc(strap_osc),
    .det_start(det_start), .det_done(det_done), .det_valid(det_valid),
    .hicap_en(hicap_en), .cls_start(cls_start), .cls_done(cls_done),
    .sw_en(sw_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic ms, input logic leg, input logic osc);
    @(negedge clk);
    rst_n = 1'b0; det_done = 1'b0; det_valid = 1'b0; cls_done = 1'b0;
    strap_midspan = ms; strap_legacy = leg; strap_osc = osc;
    repeat (3) @(negedge clk);
    chk(!det_start && !cls_start && !sw_en, "R1 strobes low in reset",
        {det_start, cls_start, sw_en}, 0);
    chk(hicap_en == 1'b1, "R1 hicap default", hicap_en, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(det_start == 1'b1, "R2 first probe", det_start, 1);
    chk(hicap_en == leg, "R3 legacy captured", hicap_en, leg);
    @(negedge clk);
    chk(det_start == 1'b0, "R2 probe one cycle", det_start, 0);
  endtask

  // fail a detection now; return edges until det_start seen
  task automatic fail_and_measure(output int gap);
    bit sw_ok;
    sw_ok = 1'b1;
    det_done = 1'b1; det_valid = 1'b0;
    @(negedge clk);
    det_done = 1'b0;
    gap = 1;
    while (!det_start && gap < 40000) begin
      @(negedge clk);
      gap++;
      if (sw_en) sw_ok = 1'b0;
    end
    chk(sw_ok, "R5 switch off in back-off", !sw_ok, 0);
  endtask

  task automatic pass_through();
    det_done = 1'b1; det_valid = 1'b1;
    @(negedge clk);
    det_done = 1'b0; det_valid = 1'b0;
    chk(cls_start == 1'b1, "R4 classify request", cls_start, 1);
    chk(sw_en == 1'b0, "R5 switch off before class", sw_en, 0);
    @(negedge clk);
    chk(cls_start == 1'b0, "R4 classify one cycle", cls_start, 0);
    cls_done = 1'b1;
    @(negedge clk);
    cls_done = 1'b0;
    chk(sw_en == 1'b1, "R4 switch on", sw_en, 1);
    repeat (6) @(negedge clk);
    chk(sw_en && !det_start, "R4 switch held", {sw_en, det_start}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gap, d, starts, seen;
    for (int v = 0; v < 4; v++) begin
      apply_reset(VEC[v][5], VEC[v][4], VEC[v][3]);
      d = VEC[v][3] ? DB : DA;
      starts = 0;
      for (int f = 0; f < int'(VEC[v][2:0]); f++) begin
        repeat (f % d + 1) @(negedge clk);   // sweep prescaler phase
        fail_and_measure(gap);
        if (det_start) starts++;
        if (VEC[v][5]) begin
          chk(gap >= BASE * d && gap <= (BASE + SPAN) * d + 1, "R6 cadence window",
              gap, BASE * d);
          if (VEC[v][3])
            chk(gap >= BASE * DB, "R9 alternate divisor", gap, BASE * DB);
        end else begin
          chk(gap >= 2 && gap <= d + 1, "R7 retry within a tick", gap, d + 1);
        end
      end
      chk(starts == int'(VEC[v][2:0]), "R8 retries continue", starts, int'(VEC[v][2:0]));
      @(negedge clk);
      pass_through();
    end

    // R3: strap changes after release are ignored
    apply_reset(1'b0, 1'b0, 1'b0);
    strap_midspan = 1'b1; strap_legacy = 1'b1; strap_osc = 1'b1;
    @(negedge clk);
    chk(hicap_en == 1'b0, "R3 legacy frozen", hicap_en, 0);
    fail_and_measure(gap);
    chk(gap >= 2 && gap <= DA + 1, "R3 midspan and osc frozen", gap, DA + 1);
    @(negedge clk);
    pass_through();

    // R10: completion strobes outside their phase
    apply_reset(1'b0, 1'b1, 1'b0);
    cls_done = 1'b1;
    @(negedge clk);
    cls_done = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sw_en && !cls_start, "R10 cls_done during detect", {sw_en, cls_start}, 0);
    det_done = 1'b1; det_valid = 1'b1;
    @(negedge clk);
    det_done = 1'b0; det_valid = 1'b0;
    chk(cls_start == 1'b1, "R4 classify after stray", cls_start, 1);
    det_done = 1'b1;
    @(negedge clk);
    det_done = 1'b0;
    seen = 0;
    for (int k = 0; k < 3 * DA + 5; k++) begin
      @(negedge clk);
      if (det_start || sw_en) seen++;
    end
    chk(seen == 0, "R10 det_done during classify", seen, 0);
    cls_done = 1'b1;
    @(negedge clk);
    cls_done = 1'b0;
    chk(sw_en == 1'b1, "R10 classify still completes", sw_en, 1);

    apply_reset(1'b1, 1'b1, 1'b0);
    det_done = 1'b1; det_valid = 1'b0;
    @(negedge clk);
    det_done = 1'b0;
    repeat (10) @(negedge clk);
    det_done = 1'b1; det_valid = 1'b1;
    @(negedge clk);
    det_done = 1'b0; det_valid = 1'b0;
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      if (cls_start || det_start) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R10 det_done during back-off", seen, 0);
    gap = 0;
    while (!det_start && gap < 20000) begin
      @(negedge clk);
      gap++;
    end
    chk(det_start == 1'b1, "R8 probe after back-off", det_start, 1);
    @(negedge clk);
    pass_through();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule